// File: doc/BRIEF.md
# SPI Master with Word-Boundary Clock Stall

This block is a serial peripheral interface master. A host reaches it through four word-wide registers: control, status, transmit data and receive data. Each data direction has a single holding register. Words are `DATA_W` bits long and travel most significant bit first. Clock polarity, clock phase and a clock divider are programmable.

A two-bit start-mode field decides which buffer condition governs the flow:
- **Write-driven mode:** a word goes out whenever the transmit holding register is loaded.
- **Read-driven mode:** a new word is exchanged whenever the receive holding register is empty.

At every word boundary the master checks that condition. When the condition blocks, the serial clock stays parked at its idle level and slave select stays asserted. Shifting resumes on its own as soon as the host refills or drains the governing register.

Host accesses never wait. A write to a full transmit register replaces the pending word. A read of an empty receive register returns at once with meaningless data. Software therefore polls the two status flags before each access.

Top module: `spi_stall_master`

## Requirements
- R1: After reset `ss_n` is 1, `sclk` equals the polarity bit, and both flags are 0. Clearing the enable bit has the same effect by the second clock edge after the control write. While disabled, writes to the transmit register are ignored and leave the transmit-full flag at 0.
- R2: The registers are selected by `host_addr`:
  - 0 is control: bit 0 enable, bit 1 clock polarity, bit 2 clock phase, bits 4:3 start mode, and the divider at bit 8 upward. It reads back as written.
  - 1 is status: bit 0 transmit full, bit 1 receive full.
  - 2 is transmit data (write).
  - 3 is receive data (read).
  
  `host_rdata` is valid in the same cycle the address is presented.
- R3: Each word carries `DATA_W` bits MSB first on `mosi`. The word gathered from `miso` in the same transfer is returned by a read of register 3.
- R4: `sclk` rests at the polarity value between words. With phase 0 the first bit is on `mosi` before the first edge, both sides sample on leading edges, and data changes on trailing edges. With phase 1 data changes on leading edges and is sampled on trailing edges.
- R5: Consecutive `sclk` edges inside a word are max(divider,1) system clock cycles apart.
- R6: In start mode 01 a word starts when the transmit register is full. The transmit-full flag is 1 in the cycle after the host write and clears on the following clock edge, when the word moves into the shifter.
- R7: In start mode 01, when the transmit register is empty at a word boundary, `sclk` stays idle and `mosi` holds its last bit. Shifting resumes after the next transmit write.
- R8: In start mode 00 a word starts whenever the receive register is empty. Receive-full sets on the clock edge that makes the final `sclk` edge. While it is set, `sclk` stays idle, and a receive read restarts shifting.
- R9: A write to a full transmit register overwrites the pending word. Only the newest word is sent, and the replaced one is never sent.
- R10: A read of an empty receive register completes in one cycle, leaves receive-full at 0, and starts no transfer in start mode 01.
- R11: Start modes 10 and 11 start no transfer, even with the transmit register full.
- R12: `ss_n` falls when the first word is loaded and stays 0 through stalls until the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from the address |
| tx_full | output | 1 | Transmit holding register occupied |
| rx_full | output | 1 | Receive holding register occupied |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench builds the block with `DATA_W` = 16 and `DIV_W` = 4. The 16-bit words use distinct MSB and LSB patterns, so a bit-order slip or a missing last bit shows up in the exchanged values. A divider of 4 gives each word 128 system cycles, which leaves room to overwrite the pending word twice while a transfer is in flight. Divider values 0, 1 and 3 show the minimum clamp and the edge spacing. The stall tests hold the clock parked for 40 cycles, which makes any spurious edge during the freeze visible.

// File: rtl/spi_stall_pkg.sv
package spi_stall_pkg;

    localparam int HOST_W = 32;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CPOL_BIT = 1;
    localparam int CTRL_CPHA_BIT = 2;
    localparam int CTRL_MODE_LSB = 3;
    localparam int CTRL_DIV_LSB  = 8;

    localparam int STAT_TXF_BIT  = 0;
    localparam int STAT_RXF_BIT  = 1;

    typedef enum logic [1:0] {
        MODE_RXREAD  = 2'b00,
        MODE_TXWRITE = 2'b01,
        MODE_RSV2    = 2'b10,
        MODE_RSV3    = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        SH_WAIT = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic       en;
        logic       cpol;
        logic       cpha;
        xfer_mode_e mode;
    } spi_cfg_t;

    // Decides whether a new word may begin at a boundary.
    function automatic logic start_allowed(xfer_mode_e m, logic txf, logic rxf);
        case (m)
            MODE_TXWRITE: return txf;
            MODE_RXREAD:  return !rxf;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // A divider of zero is treated as one.
    always_comb begin
        if (div == '0) lim = '0;
        else           lim = div - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= lim);

    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_stall_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              go,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              load,
    output logic              done,
    output logic              run,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n
);

    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    sh_state_e         state;
    logic [EDGE_W-1:0] edge_cnt;
    logic              lvl;
    logic [DATA_W-1:0] shreg;
    logic              samp;
    logic              ss_q;
    logic              lead;
    logic              last;

    assign lead = !lvl;
    assign last = (edge_cnt == LAST_EDGE);
    assign run  = (state == SH_RUN);
    assign load = en && (state == SH_WAIT) && go;
    assign done = run && tick && last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state    <= SH_WAIT;
            edge_cnt <= '0;
            lvl      <= 1'b0;
            shreg    <= '0;
            samp     <= 1'b0;
            ss_q     <= 1'b1;
        end else begin
            case (state)
                SH_WAIT: begin
                    if (go) begin
                        shreg    <= tx_word;
                        edge_cnt <= '0;
                        lvl      <= 1'b0;
                        ss_q     <= 1'b0;
                        state    <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (tick) begin
                        lvl      <= !lvl;
                        edge_cnt <= last ? '0 : edge_cnt + 1'b1;
                        if (last) state <= SH_WAIT;
                        if (!cpha) begin
                            if (lead)       samp  <= miso;
                            else if (!last) shreg <= {shreg[DATA_W-2:0], samp};
                        end else begin
                            if (lead && edge_cnt != '0) shreg <= {shreg[DATA_W-2:0], samp};
                            else if (!lead)             samp  <= miso;
                        end
                    end
                end
                default: state <= SH_WAIT;
            endcase
        end
    end

    assign rx_word = cpha ? {shreg[DATA_W-2:0], miso} : {shreg[DATA_W-2:0], samp};
    assign sclk    = cpol ^ lvl;
    assign mosi    = shreg[DATA_W-1];
    assign ss_n    = ss_q;

    a_r12_ss_low_in_word: assert property (@(posedge clk) disable iff (rst)
        (state == SH_RUN) |-> !ss_n);

    a_r4_sclk_idle_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (state == SH_WAIT) |-> (sclk == cpol));

    a_r1_disable_idles: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ss_n && state == SH_WAIT));

    a_r7_mosi_hold_in_stall: assert property (@(posedge clk) disable iff (rst)
        (en && state == SH_WAIT && !go) |=> $stable(mosi));

endmodule

// File: rtl/spi_regif.sv
module spi_regif
    import spi_stall_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              load,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    output spi_cfg_t          cfg,
    output logic [DIV_W-1:0]  div,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_full,
    output logic              rx_full
);

    reg_addr_e         sel;
    logic              wr_ctrl;
    logic              wr_tx;
    logic              rd_rx;
    logic [DATA_W-1:0] rx_data;
    logic [HOST_W-1:0] rx_ext;
    logic [HOST_W-1:0] ctrl_ext;
    logic [HOST_W-1:0] stat_ext;

    assign sel     = reg_addr_e'(host_addr);
    assign wr_ctrl = host_we && (sel == REG_CTRL);
    assign wr_tx   = host_we && (sel == REG_TXD);
    assign rd_rx   = host_re && (sel == REG_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            div <= '0;
        end else if (wr_ctrl) begin
            cfg.en   <= host_wdata[CTRL_EN_BIT];
            cfg.cpol <= host_wdata[CTRL_CPOL_BIT];
            cfg.cpha <= host_wdata[CTRL_CPHA_BIT];
            cfg.mode <= xfer_mode_e'(host_wdata[CTRL_MODE_LSB +: 2]);
            div      <= host_wdata[CTRL_DIV_LSB +: DIV_W];
        end
    end

    // Transmit holding register: host write wins over a same-cycle load.
    always_ff @(posedge clk) begin
        if (rst || !cfg.en) tx_full <= 1'b0;
        else if (wr_tx)     tx_full <= 1'b1;
        else if (load)      tx_full <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                    tx_word <= '0;
        else if (cfg.en && wr_tx)   tx_word <= host_wdata[DATA_W-1:0];
    end

    // Receive holding register: a completed word wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (rst || !cfg.en) rx_full <= 1'b0;
        else if (done)      rx_full <= 1'b1;
        else if (rd_rx)     rx_full <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                  rx_data <= '0;
        else if (cfg.en && done)  rx_data <= rx_word;
    end

    generate
        if (DATA_W < HOST_W) begin : g_pad
            assign rx_ext = {{(HOST_W-DATA_W){1'b0}}, rx_data};
        end else begin : g_full
            assign rx_ext = rx_data[HOST_W-1:0];
        end
    endgenerate

    always_comb begin
        ctrl_ext = '0;
        ctrl_ext[CTRL_EN_BIT]              = cfg.en;
        ctrl_ext[CTRL_CPOL_BIT]            = cfg.cpol;
        ctrl_ext[CTRL_CPHA_BIT]            = cfg.cpha;
        ctrl_ext[CTRL_MODE_LSB +: 2]       = cfg.mode;
        ctrl_ext[CTRL_DIV_LSB +: DIV_W]    = div;
        stat_ext = '0;
        stat_ext[STAT_TXF_BIT]             = tx_full;
        stat_ext[STAT_RXF_BIT]             = rx_full;
    end

    always_comb begin
        case (sel)
            REG_CTRL: host_rdata = ctrl_ext;
            REG_STAT: host_rdata = stat_ext;
            REG_RXD:  host_rdata = rx_ext;
            default:  host_rdata = '0;
        endcase
    end

    a_r6_load_empties_tx: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && load && !wr_tx) |=> !tx_full);

    a_r9_write_replaces_tx: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && wr_tx) |=> (tx_full && tx_word == $past(host_wdata[DATA_W-1:0])));

    a_r8_done_fills_rx: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && done) |=> rx_full);

    a_r10_empty_read_no_flag: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && !rx_full && !done) |=> !rx_full);

endmodule

// File: rtl/spi_stall_master.sv
module spi_stall_master
    import spi_stall_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_re,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        tx_full,
    output logic        rx_full,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        ss_n
);

    spi_cfg_t          cfg;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_word;
    logic              load;
    logic              done;
    logic              run;
    logic              tick;
    logic              go;

    assign go = start_allowed(cfg.mode, tx_full, rx_full);

    spi_regif #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regif (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .load       (load),
        .done       (done),
        .rx_word    (rx_word),
        .cfg        (cfg),
        .div        (div),
        .tx_word    (tx_word),
        .tx_full    (tx_full),
        .rx_full    (rx_full)
    );

    spi_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (div),
        .tick (tick)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg.en),
        .cpol    (cfg.cpol),
        .cpha    (cfg.cpha),
        .go      (go),
        .tick    (tick),
        .tx_word (tx_word),
        .miso    (miso),
        .load    (load),
        .done    (done),
        .run     (run),
        .rx_word (rx_word),
        .sclk    (sclk),
        .mosi    (mosi),
        .ss_n    (ss_n)
    );

    a_r11_reserved_mode_idle: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_RSV2 || cfg.mode == MODE_RSV3) |-> !load);

endmodule

// File: tb/tb_spi_stall_master.sv
module tb_spi_stall_master;

    localparam int W  = 16;
    localparam int DW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        tx_full, rx_full, sclk, mosi, miso, ss_n;

    always #4 clk = ~clk;

    spi_stall_master #(.DATA_W(W), .DIV_W(DW)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_full(tx_full), .rx_full(rx_full), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Slave model state (written only by the monitor below).
    int   cyc = 0, e = 0, bi = 0, n_got = 0, n_sent = 0, edges_total = 0;
    int   last_edge_cyc = 0, last_gap = 0, clr_seen = 0;
    logic [W-1:0] slv_rx = '0;
    logic [W-1:0] got [8];
    logic miso_q = 1'b0;
    logic sclk_prev = 1'b0;
    // Written only by the stimulus.
    int   clr_req = 0;
    bit   cur_cpha = 0;

    assign miso = miso_q;

    function automatic logic [W-1:0] sw(int n);
        return W'(32'h96C3 + n * 32'h2345);
    endfunction

    function automatic logic [31:0] mk_ctrl(bit en, bit cpol, bit cpha, logic [1:0] mode, int div);
        return (32'(div) << 8) | (32'(mode) << 3) | (32'(cpha) << 2) | (32'(cpol) << 1) | 32'(en);
    endfunction

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clr_req != clr_seen) begin
            clr_seen = clr_req;
            n_got = 0; n_sent = 0; e = 0; bi = 0; edges_total = 0;
            miso_q = sw(0)[W-1];
        end else if (ss_n) begin
            e = 0; bi = 0;
            miso_q = sw(n_sent)[W-1];
        end else if (sclk != sclk_prev) begin
            edges_total = edges_total + 1;
            if (e > 0) last_gap = cyc - last_edge_cyc;
            last_edge_cyc = cyc;
            e = e + 1;
            if ((!cur_cpha && e[0]) || (cur_cpha && !e[0]))
                slv_rx = {slv_rx[W-2:0], mosi};
            if (e == 2 * W) begin
                got[n_got % 8] = slv_rx;
                n_got = n_got + 1;
                n_sent = n_sent + 1;
                e = 0; bi = 0;
                if (!cur_cpha) miso_q = sw(n_sent)[W-1];
            end else if (!cur_cpha && !e[0]) begin
                bi = bi + 1;
                miso_q = sw(n_sent)[W-1-bi];
            end else if (cur_cpha && e[0]) begin
                miso_q = sw(n_sent)[W-1-bi];
                bi = bi + 1;
            end
        end
        sclk_prev = sclk;
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        #1;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_re = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_re = 1'b0;
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic configure(bit cpol, bit cpha, logic [1:0] mode, int div);
        reg_write(2'd0, mk_ctrl(0, cpol, cpha, mode, div));
        cur_cpha = cpha;
        clr_req++;
        idle(2);
        reg_write(2'd0, mk_ctrl(1, cpol, cpha, mode, div));
    endtask

    task automatic wait_words(int n, string req);
        int k = 0;
        while (n_got < n && k < 5000) begin
            @(negedge clk); #1; k++;
        end
        check(n_got >= n, req, n_got, n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(ss_n == 1'b1, "R1 ss_n after reset", ss_n, 1);
        check(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        check(tx_full == 1'b0 && rx_full == 1'b0, "R1 flags after reset", {tx_full, rx_full}, 0);
        reg_read(2'd1, d);
        check(d == 0, "R2 status after reset", d, 0);
        reg_write(2'd0, mk_ctrl(0, 1, 1, 2'b10, 9));
        reg_read(2'd0, d);
        check(d == mk_ctrl(0, 1, 1, 2'b10, 9), "R2 control readback", d, mk_ctrl(0, 1, 1, 2'b10, 9));
    endtask

    task automatic t_modes();
        logic [31:0] d;
        for (int m = 0; m < 4; m++) begin
            logic [W-1:0] dat;
            dat = W'(32'hB1E4 ^ (m * 32'h1357));
            configure(m[1], m[0], 2'b01, 2);
            reg_write(2'd2, 32'(dat));
            check(tx_full == 1'b1, "R6 tx_full set after write", tx_full, 1);
            idle(1);
            check(tx_full == 1'b0, "R6 tx_full cleared on load", tx_full, 0);
            wait_words(1, "R4 word completes");
            check(got[0] == dat, "R3 R4 slave received word", got[0], dat);
            check(rx_full == 1'b1, "R8 rx_full after final edge", rx_full, 1);
            check(sclk == m[1], "R4 sclk idle level", sclk, m[1]);
            reg_read(2'd3, d);
            check(d == 32'(sw(0)), "R3 R4 master received word", d, sw(0));
            reg_read(2'd1, d);
            check(d == 0, "R2 status after drain", d, 0);
        end
    endtask

    task automatic t_divider();
        configure(0, 0, 2'b01, 3);
        reg_write(2'd2, 32'h00F0);
        wait_words(1, "R5 word at divider 3");
        check(last_gap == 3, "R5 half period at divider 3", last_gap, 3);
        configure(0, 0, 2'b01, 0);
        reg_write(2'd2, 32'h0F0F);
        wait_words(1, "R5 word at divider 0");
        check(last_gap == 1, "R5 divider 0 acts as 1", last_gap, 1);
    endtask

    task automatic t_stall_tx();
        int   snap;
        logic m_snap;
        configure(1, 1, 2'b01, 1);
        reg_write(2'd2, 32'h8001);
        wait_words(1, "R7 first word");
        snap = edges_total; m_snap = mosi;
        idle(40);
        check(edges_total == snap, "R7 no edges while tx empty", edges_total, snap);
        check(sclk == 1'b1, "R7 sclk parked idle", sclk, 1);
        check(mosi == m_snap, "R7 mosi holds last bit", mosi, m_snap);
        check(ss_n == 1'b0, "R12 ss_n held through stall", ss_n, 0);
        reg_write(2'd2, 32'h7E5A);
        wait_words(2, "R7 resume after write");
        check(got[1] == 16'h7E5A, "R7 resumed word", got[1], 16'h7E5A);
    endtask

    task automatic t_overwrite();
        configure(0, 0, 2'b01, 4);
        reg_write(2'd2, 32'h1111);
        idle(4);
        reg_write(2'd2, 32'hAAAA);
        reg_write(2'd2, 32'hBBBB);
        check(tx_full == 1'b1, "R9 tx_full while pending", tx_full, 1);
        wait_words(2, "R9 second word");
        check(got[1] == 16'hBBBB, "R9 newest word sent", got[1], 16'hBBBB);
        idle(200);
        check(n_got == 2, "R9 replaced word never sent", n_got, 2);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        configure(0, 0, 2'b01, 1);
        reg_read(2'd3, d);
        check(rx_full == 1'b0, "R10 rx_full after empty read", rx_full, 0);
        idle(20);
        check(edges_total == 0, "R10 no transfer after empty read", edges_total, 0);
        check(ss_n == 1'b1, "R10 R12 ss_n stays high", ss_n, 1);
        reg_read(2'd1, d);
        check(d == 0, "R10 status after empty read", d, 0);
    endtask

    task automatic t_mode00();
        logic [31:0] d;
        int snap;
        configure(0, 0, 2'b10, 1);
        reg_write(2'd2, 32'hC0DE);
        idle(30);
        check(edges_total == 0, "R11 reserved mode starts nothing", edges_total, 0);
        check(tx_full == 1'b1, "R11 tx stays full", tx_full, 1);
        reg_write(2'd0, mk_ctrl(1, 0, 0, 2'b00, 1));
        wait_words(1, "R8 read-driven word");
        check(rx_full == 1'b1, "R8 rx_full at final edge", rx_full, 1);
        check(got[0] == 16'hC0DE, "R8 word sent in read-driven mode", got[0], 16'hC0DE);
        snap = edges_total;
        idle(40);
        check(edges_total == snap, "R8 stall while rx full", edges_total, snap);
        check(ss_n == 1'b0 && sclk == 1'b0, "R8 R12 parked with ss_n low", {ss_n, sclk}, 0);
        reg_read(2'd3, d);
        check(d == 32'(sw(0)), "R8 first received word", d, sw(0));
        wait_words(2, "R8 resume after read");
        reg_read(2'd3, d);
        check(d == 32'(sw(1)), "R8 second received word", d, sw(1));
    endtask

    task automatic t_disable();
        logic [31:0] d;
        configure(1, 0, 2'b01, 4);
        reg_write(2'd2, 32'h5555);
        idle(20);
        reg_write(2'd2, 32'h6666);
        reg_write(2'd0, mk_ctrl(0, 1, 0, 2'b01, 4));
        idle(1);
        check(ss_n == 1'b1, "R1 ss_n after disable", ss_n, 1);
        check(sclk == 1'b1, "R1 sclk idle after disable", sclk, 1);
        check(tx_full == 1'b0 && rx_full == 1'b0, "R1 flags after disable", {tx_full, rx_full}, 0);
        reg_write(2'd2, 32'h7777);
        reg_read(2'd1, d);
        check(d == 0, "R1 tx write ignored while disabled", d, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_modes();
        t_divider();
        t_stall_tx();
        t_overwrite();
        t_empty_read();
        t_mode00();
        t_disable();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule